// File: doc/BRIEF.md
# Repeated-Evaluation Majority Vote Sampler

This block sits in front of a bank of parallel race-response sources. Each source returns one noisy bit per evaluation. A serial chain, stepped one bit per enable, loads a wide challenge. A capture command then applies that challenge to every source and runs a fixed, odd number of evaluations back to back.

Each lane has a counter that tallies the ones its source returns. When the last evaluation finishes, the majority bit of every lane is written into the low end of the same serial chain, where it can be shifted out. The sources run a level handshake. The sampler raises `src_start`, and each source raises its own `src_done` with a valid `src_bit`, holding both until `src_start` falls. A source drops `src_done` once `src_start` is low. Lanes may finish in any order.

The defaults are 64 challenge bits, 8 lanes and 11 evaluations. With these defaults a lane reports 1 when it has counted 6 or more ones.

Top module: `vote_sampler`

## Requirements
- R1: Shift steps are a cycle with `sh_step`=1 and `sh_capture`=0 while not busy. After 64 such steps, chain position j holds the bit that was presented on the j-th step, counting from 0. The capture command copies the chain onto `chal`, and `chal` holds that value for the whole measurement.
- R2: `sh_dout` always shows chain position 0, and each shift step moves every chain bit one position toward position 0. When a measurement ends, positions 0..7 are loaded with the result, lane i at position i. Positions 8..63 keep the challenge bits.
- R3: A capture command is a cycle with `sh_step`=1 and `sh_capture`=1 while not busy. `busy` rises in the cycle after the command. It stays high until the result is loaded into the chain, and falls in that same edge.
- R4: One capture command causes exactly 11 rising edges of `src_start`.
- R5: `src_start` is high only while `busy` is high. Before each rise it has been low for at least one cycle, with every `src_done` low.
- R6: Each lane samples `src_bit` once per evaluation, on its own `src_done`. An evaluation completes only when every lane has reported, whatever their order and latency.
- R7: A lane's result bit is 1 exactly when at least 6 of its 11 sampled bits were 1. The boundary counts 0, 5, 6 and 11 are covered by this rule.
- R8: Shift steps and capture commands made while `busy` is high have no effect on the chain, on `chal` or on the number of evaluations.
- R9: After reset, `busy` and `src_start` are low and the chain is all zeros, so `sh_dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sh_din | input | 1 | Serial data entering the chain at the top position |
| sh_step | input | 1 | Step enable for the serial interface |
| sh_capture | input | 1 | With sh_step: 1 launches a measurement, 0 shifts |
| sh_dout | output | 1 | Chain position 0 |
| busy | output | 1 | Measurement in progress |
| chal | output | CHAL_W | Challenge applied to the sources |
| src_start | output | 1 | Evaluation request to all sources |
| src_done | input | LANES | Per-source completion flag |
| src_bit | input | LANES | Per-source response bit, valid with src_done |

## Verification
The bench sweeps every ones-count from 0 to 11 through every lane, including the 5/6 split. A threshold that is off by one, or a counter that wraps, would flip a lane at exactly that split. Source latencies are staggered per lane and per evaluation, so a design that sampled all lanes on the first `src_done` would tally bits that are not yet valid. A design that re-sampled a held `src_done` would also miscount.

Every result is shifted out with the full upper chain while the next challenge shifts in. A design that shifted during busy, clobbered the upper bits or mis-ordered the lanes would show a corrupted readout. Extra shift and capture commands are fired mid-measurement, and the bench counts the rises of `src_start`. A design that honoured those commands would then show a changed challenge or a count other than 11.

// File: rtl/vote_sampler_pkg.sv
package vote_sampler_pkg;

   typedef enum logic [1:0] {
      VS_IDLE = 2'd0,
      VS_RUN  = 2'd1,
      VS_GAP  = 2'd2
   } vs_state_e;

   function automatic int vs_threshold(input int reps);
      return reps / 2 + 1;
   endfunction

endpackage

// File: rtl/vote_sampler_lane.sv
module vote_sampler_lane #(
   parameter int REPS  = 11,
   parameter int CNT_W = $clog2(REPS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_all,
   input  logic clr_got,
   input  logic start,
   input  logic done,
   input  logic bit_in,
   output logic got,
   output logic vote
);
   import vote_sampler_pkg::*;

   localparam int THRESH = vs_threshold(REPS);

   logic [CNT_W-1:0] ones_q;
   logic             got_q;

   // One sample per evaluation: the first cycle done is seen with start high.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ones_q <= '0;
         got_q  <= 1'b0;
      end else if (clr_all) begin
         ones_q <= '0;
         got_q  <= 1'b0;
      end else if (clr_got) begin
         got_q  <= 1'b0;
      end else if (start && done && !got_q) begin
         got_q  <= 1'b1;
         ones_q <= ones_q + {{(CNT_W-1){1'b0}}, bit_in};
      end
   end

   assign got  = got_q;
   assign vote = (ones_q >= CNT_W'(THRESH));

endmodule

// File: rtl/vote_sampler_seq.sv
module vote_sampler_seq #(
   parameter int REPS  = 11,
   parameter int REP_W = $clog2(REPS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_cmd,
   input  logic             all_got,
   input  logic             none_done,
   output logic             start,
   output logic             busy,
   output logic             clr_all,
   output logic             clr_got,
   output logic             load_res,
   output logic [REP_W-1:0] rep_cnt
);
   import vote_sampler_pkg::*;

   vs_state_e        st_q;
   logic [REP_W-1:0] rep_q;
   logic             last_rep;

   assign last_rep = (rep_q == REP_W'(REPS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= VS_IDLE;
         rep_q <= '0;
      end else begin
         unique case (st_q)
            VS_IDLE: if (cap_cmd) begin
               st_q  <= VS_RUN;
               rep_q <= '0;
            end
            VS_RUN: if (all_got) begin
               st_q  <= VS_GAP;
               rep_q <= rep_q + 1'b1;
            end
            VS_GAP: if (none_done) begin
               st_q <= last_rep ? VS_IDLE : VS_RUN;
            end
            default: st_q <= VS_IDLE;
         endcase
      end
   end

   always_comb begin
      start    = (st_q == VS_RUN);
      busy     = (st_q != VS_IDLE);
      clr_all  = (st_q == VS_IDLE) && cap_cmd;
      clr_got  = (st_q == VS_RUN) && all_got;
      load_res = (st_q == VS_GAP) && none_done && last_rep;
   end

   assign rep_cnt = rep_q;

endmodule

// File: rtl/vote_sampler_chain.sv
module vote_sampler_chain #(
   parameter int W  = 64,
   parameter int RW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          shift_go,
   input  logic          ser_in,
   input  logic          load,
   input  logic [RW-1:0] res,
   output logic [W-1:0]  q,
   output logic          ser_out
);
   logic [W-1:0] q_r;

   // Entry at the top, exit at position 0: first bit in ends at position 0.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_r <= '0;
      end else if (load) begin
         q_r[RW-1:0] <= res;
      end else if (shift_go) begin
         q_r <= {ser_in, q_r[W-1:1]};
      end
   end

   assign q       = q_r;
   assign ser_out = q_r[0];

endmodule

// File: rtl/vote_sampler.sv
module vote_sampler #(
   parameter int CHAL_W = 64,
   parameter int LANES  = 8,
   parameter int REPS   = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sh_din,
   input  logic              sh_step,
   input  logic              sh_capture,
   output logic              sh_dout,
   output logic              busy,
   output logic [CHAL_W-1:0] chal,
   output logic              src_start,
   input  logic [LANES-1:0]  src_done,
   input  logic [LANES-1:0]  src_bit
);
   localparam int CNT_W = $clog2(REPS + 1);

   if (REPS % 2 == 0) begin : g_bad_reps
      $error("REPS must be odd for a strict majority");
   end
   if (LANES > CHAL_W || LANES < 1) begin : g_bad_lanes
      $error("LANES must fit inside the chain");
   end

   logic              cap_cmd, shift_go;
   logic              clr_all, clr_got, load_res;
   logic              all_got, none_done;
   logic [LANES-1:0]  got_v, vote_v;
   logic [CNT_W-1:0]  rep_cnt;
   logic [CHAL_W-1:0] chain_q;
   logic [CHAL_W-1:0] chal_q;

   assign cap_cmd   = sh_step && sh_capture && !busy;
   assign shift_go  = sh_step && !sh_capture && !busy;
   assign all_got   = &got_v;
   assign none_done = ~|src_done;

   vote_sampler_seq #(.REPS(REPS), .REP_W(CNT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_cmd   (cap_cmd),
      .all_got   (all_got),
      .none_done (none_done),
      .start     (src_start),
      .busy      (busy),
      .clr_all   (clr_all),
      .clr_got   (clr_got),
      .load_res  (load_res),
      .rep_cnt   (rep_cnt)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      vote_sampler_lane #(.REPS(REPS), .CNT_W(CNT_W)) u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr_all (clr_all),
         .clr_got (clr_got),
         .start   (src_start),
         .done    (src_done[i]),
         .bit_in  (src_bit[i]),
         .got     (got_v[i]),
         .vote    (vote_v[i])
      );
   end

   vote_sampler_chain #(.W(CHAL_W), .RW(LANES)) u_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_go (shift_go),
      .ser_in   (sh_din),
      .load     (load_res),
      .res      (vote_v),
      .q        (chain_q),
      .ser_out  (sh_dout)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chal_q <= '0;
      else if (clr_all) chal_q <= chain_q;
   end

   assign chal = chal_q;

endmodule

// File: rtl/vote_sampler_chk.sv
module vote_sampler_chk #(
   parameter int CHAL_W = 64,
   parameter int LANES  = 8,
   parameter int REPS   = 11,
   parameter int CNT_W  = $clog2(REPS + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sh_step,
   input logic              sh_capture,
   input logic              busy,
   input logic              src_start,
   input logic [LANES-1:0]  src_done,
   input logic [CHAL_W-1:0] chal,
   input logic [CHAL_W-1:0] chain_q,
   input logic [CNT_W-1:0]  rep_cnt
);
   a_r3_busy_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_step && sh_capture && !busy) |=> busy);

   a_r5_start_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      src_start |-> busy);

   a_r5_rearm_clean: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(src_start) |-> ($past(src_done) == '0));

   a_r8_chain_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(chain_q));

   a_r1_chal_held: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(chal));

   a_r4_rep_bound: assert property (@(posedge clk) disable iff (!rst_n)
      rep_cnt <= CNT_W'(REPS));
endmodule

bind vote_sampler vote_sampler_chk #(
   .CHAL_W(CHAL_W), .LANES(LANES), .REPS(REPS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sh_step    (sh_step),
   .sh_capture (sh_capture),
   .busy       (busy),
   .src_start  (src_start),
   .src_done   (src_done),
   .chal       (chal),
   .chain_q    (chain_q),
   .rep_cnt    (rep_cnt)
);

// File: tb/vote_sampler_bench.sv
`timescale 1ns/1ps
module vote_sampler_bench;
   localparam int CW = 64, L = 8, N = 11;

   logic clk = 0, rst_n = 0;
   logic sh_din = 0, sh_step = 0, sh_capture = 0;
   logic sh_dout, busy, src_start;
   logic [CW-1:0] chal;
   logic [L-1:0]  src_done = '0, src_bit = '0;

   int vecs = 0, bad = 0, rises = 0, ev = 0, viol = 0;
   logic prev_s = 0;
   int wcnt [L];
   bit ended = 0;

   always #2.5 clk = ~clk;

   vote_sampler #(.CHAL_W(CW), .LANES(L), .REPS(N)) u_vote_sampler (.*);

   function automatic int ones_for(input logic [CW-1:0] c, input int i);
      return int'(c[i*4 +: 4]);
   endfunction

   function automatic logic mbit(input logic [CW-1:0] c, input int i, input int k);
      return ((k * 7 + i * 3) % 11) < ones_for(c, i);
   endfunction

   // Start monitor: values seen here are the ones before the edge updates.
   always @(posedge clk) begin
      if (src_start && !prev_s) rises++;
      if (!src_start && prev_s) ev++;
      if (src_start && !busy) viol++;
      prev_s = src_start;
   end

   // Source model, driven away from the active edge.
   always @(negedge clk) begin
      for (int i = 0; i < L; i++) begin
         if (!src_start) begin
            src_done[i] = 1'b0;
            wcnt[i] = 0;
         end else if (!src_done[i]) begin
            if (wcnt[i] >= 1 + ((i + ev) % 5)) begin
               src_bit[i]  = mbit(chal, i, ev);
               src_done[i] = 1'b1;
            end else wcnt[i]++;
         end
      end
   end

   task automatic check(input bit ok, input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
      vecs++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic xfer(input logic [CW-1:0] din, output logic [CW-1:0] dout);
      for (int j = 0; j < CW; j++) begin
         @(negedge clk);
         sh_step = 1; sh_capture = 0; sh_din = din[j];
         dout[j] = sh_dout;
         @(posedge clk);
      end
      @(negedge clk);
      sh_step = 0;
   endtask

   initial begin
      logic [CW-1:0] c, rd, prev_exp;
      logic [L-1:0]  res;
      int r0, guard;
      repeat (3) @(negedge clk);
      check(busy == 0, "R9 busy", CW'(busy), 0);
      check(src_start == 0, "R9 start", CW'(src_start), 0);
      check(sh_dout == 0, "R9 dout", CW'(sh_dout), 0);
      rst_n = 1;
      prev_exp = '0;
      for (int t = 0; t < 12; t++) begin
         c[63:32] = 32'(t) * 32'h9E3779B1 ^ 32'h5A5A0F0F;
         for (int i = 0; i < L; i++) c[i*4 +: 4] = 4'((t + i) % 12);
         res = '0;
         for (int i = 0; i < L; i++) res[i] = (ones_for(c, i) >= 6);
         xfer(c, rd);
         check(rd == prev_exp, "R2 readout", rd, prev_exp);
         // capture command
         @(negedge clk);
         sh_step = 1; sh_capture = 1;
         r0 = rises;
         @(posedge clk);
         @(negedge clk);
         sh_step = 0; sh_capture = 0;
         check(busy == 1, "R3 busy rise", CW'(busy), 1);
         check(chal == c, "R1 chal applied", chal, c);
         if (t % 2 == 1) begin
            for (int j = 0; j < 3; j++) begin
               @(negedge clk);
               sh_step = 1; sh_capture = 0; sh_din = 1;
            end
            @(negedge clk);
            sh_capture = 1;
            @(negedge clk);
            sh_step = 0; sh_capture = 0;
            check(chal == c, "R8 chal kept", chal, c);
         end
         guard = 0;
         while (busy && guard < 3000) begin
            @(negedge clk);
            guard++;
         end
         check(!busy, "R3 busy fall", CW'(busy), 0);
         check(rises - r0 == N, "R4 R8 evals", CW'(rises - r0), CW'(N));
         check(sh_dout == res[0], "R7 R6 lane0", CW'(sh_dout), CW'(res[0]));
         prev_exp = {c[CW-1:L], res};
      end
      xfer('0, rd);
      check(rd == prev_exp, "R2 R7 final readout", rd, prev_exp);
      check(viol == 0, "R5 start outside busy", CW'(viol), 0);
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!ended) begin
         vecs++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
         $finish;
      end
   end
endmodule